// File: doc/BRIEF.md
# Burst-Dimming Envelope Generator with Staggered Two-Channel Drive

This block sets lamp brightness by switching the lamp drive on and off at a low rate. While the on/off envelope is high, two gate-enable outputs alternate at a lamp frequency set by a programmable divider. While it is low, neither output is driven. The envelope has two possible sources. It can be built locally from a 7-bit brightness code, stepped by a slow dimming-clock tick. It can also be taken from an external sync input, so that several devices follow one master.

When the envelope is built locally, it can be driven out on a sync output so that other devices can use it. The two channels share one envelope. Their lamp-frequency turn-on edges are offset by half a lamp period, which spreads the supply inrush. All logic runs on one fast system clock. The dimming clock arrives as a one-cycle tick in that clock domain.

Top module: `burst_dimmer`

## Requirements
- R1: In local mode with held code c (0..127), each period of 128 dimming ticks keeps the envelope high for exactly c+1 consecutive ticks, starting at the first tick of the period. Code 127 gives an envelope that is always high. Code 0 gives one tick on.
- R2: Whenever the envelope is low, both `gate_a` and `gate_b` are 0.
- R3: With `src_ext`=1, the envelope follows `sync_in` with a latency of exactly three system-clock cycles (two synchronizer stages and one output register).
- R4: `sync_oe` is 1 exactly when `src_ext`=0 and `sync_out_dis`=0. `sync_out` equals the envelope while `sync_oe` is 1 and is 0 otherwise.
- R5: Let H be `lamp_half`, with 0 treated as 1. While the envelope is high, `gate_a` is 1 for the first H cycles after the envelope rises. `gate_b` is then 1 for the next H cycles, and the two keep alternating. They are never 1 at the same time.
- R6: With `src_ext`=1, changes to `level` and activity on `dim_tick` have no effect on the gate outputs.
- R7: A new `level` value takes effect only from the start of the next 128-tick period. Changing it in mid-period leaves the length of the current on-time unchanged.
- R8: While `rst_n` is low, `gate_a`, `gate_b` and `sync_out` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dim_tick | input | 1 | One-cycle dimming-clock step |
| level | input | 7 | Brightness code |
| src_ext | input | 1 | 1: envelope from `sync_in`, 0: local |
| sync_out_dis | input | 1 | 1: do not drive the sync output |
| lamp_half | input | 8 | Lamp half-period in system clocks |
| sync_in | input | 1 | External envelope input |
| sync_out | output | 1 | Envelope forwarded to other devices |
| sync_oe | output | 1 | Output enable for the sync pin |
| gate_a | output | 1 | Channel A gate enable |
| gate_b | output | 1 | Channel B gate enable |

## Verification
The hardest case to reach is a brightness change that lands mid-period. To show that the change waits for the next period, the stimulus has to know where a period begins, and the ports do not report this. The bench therefore watches `sync_out` for the rising edge of the envelope, which marks the first tick of each period. It writes the new code right after that edge and measures the current on-time and then the next one. Random codes are always applied one full discarded period before they are measured. This removes any race between a write and the code load.

// File: rtl/bd_pkg.sv
package bd_pkg;
  typedef enum logic [0:0] {
    SRC_LOCAL    = 1'b0,
    SRC_EXTERNAL = 1'b1
  } env_src_e;
endpackage

// File: rtl/bd_sync.sv
module bd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb chain_d = d;
    end else begin : g_many
      always_comb chain_d = {chain_q[STAGES-2:0], d};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/bd_burst_gen.sv
module bd_burst_gen #(
  parameter int LEVEL_W = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic               tick,
  input  logic [LEVEL_W-1:0] level,
  output logic               env
);
  localparam logic [LEVEL_W-1:0] LAST_STEP = '1;

  logic [LEVEL_W-1:0] step_q, step_d;
  logic [LEVEL_W-1:0] held_q, held_d;
  logic               adv;
  logic               wrap;

  // Step counter advances on a tick only while the local source is in use
  always_comb begin
    adv    = run && tick;
    wrap   = adv && (step_q == LAST_STEP);
    step_d = adv ? step_q + 1'b1 : step_q;
    held_d = wrap ? level : held_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= '0;
      held_q <= '0;
    end else begin
      step_q <= step_d;
      held_q <= held_d;
    end
  end

  // On for steps 0..held: held+1 ticks out of 2**LEVEL_W
  assign env = (step_q <= held_q);
endmodule

// File: rtl/bd_lamp_phaser.sv
module bd_lamp_phaser #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             env,
  input  logic [DIV_W-1:0] half,
  output logic             gate_a,
  output logic             gate_b
);
  logic [DIV_W-1:0] half_eff;
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             tgl_q, tgl_d;
  logic             flip;

  always_comb begin
    half_eff = (half == '0) ? {{(DIV_W-1){1'b0}}, 1'b1} : half;
    flip     = (cnt_q >= half_eff - 1'b1);
    if (!env) begin
      cnt_d = '0;
      tgl_d = 1'b0;
    end else if (flip) begin
      cnt_d = '0;
      tgl_d = ~tgl_q;
    end else begin
      cnt_d = cnt_q + 1'b1;
      tgl_d = tgl_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      tgl_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      tgl_q <= tgl_d;
    end
  end

  // Channel B is channel A shifted by one half lamp period
  assign gate_a = env & ~tgl_q;
  assign gate_b = env &  tgl_q;
endmodule

// File: rtl/burst_dimmer.sv
module burst_dimmer #(
  parameter int LEVEL_W     = 7,
  parameter int DIV_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               dim_tick,
  input  logic [LEVEL_W-1:0] level,
  input  logic               src_ext,
  input  logic               sync_out_dis,
  input  logic [DIV_W-1:0]   lamp_half,
  input  logic               sync_in,
  output logic               sync_out,
  output logic               sync_oe,
  output logic               gate_a,
  output logic               gate_b
);
  import bd_pkg::*;

  logic [1:0]    rst_pipe_q;
  logic          rst_int_n;
  env_src_e      src;
  logic          env_local;
  logic          env_remote;
  logic          env_d, env_q;

  // Reset asserts at once, releases on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  assign src = env_src_e'(src_ext);

  bd_burst_gen #(.LEVEL_W(LEVEL_W)) u_gen (
    .clk   (clk),
    .rst_n (rst_int_n),
    .run   (src == SRC_LOCAL),
    .tick  (dim_tick),
    .level (level),
    .env   (env_local)
  );

  bd_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .d     (sync_in),
    .q     (env_remote)
  );

  always_comb env_d = (src == SRC_EXTERNAL) ? env_remote : env_local;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) env_q <= 1'b0;
    else            env_q <= env_d;
  end

  bd_lamp_phaser #(.DIV_W(DIV_W)) u_phase (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .env    (env_q),
    .half   (lamp_half),
    .gate_a (gate_a),
    .gate_b (gate_b)
  );

  assign sync_oe  = (src == SRC_LOCAL) && !sync_out_dis;
  assign sync_out = sync_oe && env_q;
endmodule

// File: rtl/burst_dimmer_chk.sv
module burst_dimmer_chk (
  input logic clk,
  input logic rst_n,
  input logic env,
  input logic sync_oe,
  input logic sync_out,
  input logic gate_a,
  input logic gate_b
);
  // R2: no drive outside the envelope
  p_gate_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !env |-> (!gate_a && !gate_b));

  // R5: channels never on together
  p_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_a && gate_b));

  // R5: channel A leads each burst
  p_a_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(env) |-> gate_a);

  // R5: channel B turns on only after channel A
  p_b_after_a_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_b) |-> $past(gate_a));

  // R4: forwarded envelope matches the internal one
  p_sync_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sync_oe |-> (sync_out == env));
endmodule

bind burst_dimmer burst_dimmer_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_int_n),
  .env      (env_q),
  .sync_oe  (sync_oe),
  .sync_out (sync_out),
  .gate_a   (gate_a),
  .gate_b   (gate_b)
);

// File: tb/burst_dimmer_tb.sv
`timescale 1ns/1ps
module burst_dimmer_tb;
  localparam int TICK_GAP = 4;

  logic       clk;
  logic       rst_n;
  logic       dim_tick;
  logic [6:0] level;
  logic       src_ext;
  logic       sync_out_dis;
  logic [7:0] lamp_half;
  logic       sync_in;
  logic       sync_out, sync_oe, gate_a, gate_b;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  burst_dimmer u_dut (
    .clk(clk), .rst_n(rst_n), .dim_tick(dim_tick), .level(level),
    .src_ext(src_ext), .sync_out_dis(sync_out_dis), .lamp_half(lamp_half),
    .sync_in(sync_in), .sync_out(sync_out), .sync_oe(sync_oe),
    .gate_a(gate_a), .gate_b(gate_b)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Free-running dimming tick, one cycle every TICK_GAP
  initial begin
    dim_tick = 1'b0;
    forever begin
      for (int i = 0; i < TICK_GAP; i++) begin
        @(negedge clk);
        dim_tick = (i == 0);
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_len(input int code);
    return (code + 1) * TICK_GAP;
  endfunction

  function automatic bit exp_a(input int k, input int h);
    int he;
    he = (h == 0) ? 1 : h;
    return ((k / he) % 2) == 0;
  endfunction

  task automatic wait_rise();
    bit prev;
    prev = sync_out;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (!prev && sync_out) return;
      prev = sync_out;
    end
  endtask

  // Called on the first high sample; returns on-time and lamp pattern errors
  task automatic measure(input int h, output int len, output int errs);
    int k;
    k = 0; errs = 0;
    while (sync_out && k < 3000) begin
      if (gate_a != exp_a(k, h) || gate_b != !exp_a(k, h)) errs++;
      k++;
      @(negedge clk);
    end
    if (gate_a || gate_b) errs++;
    len = k;
  endtask

  task automatic level_case(input int code, input int h);
    int len, errs;
    level = code[6:0];
    lamp_half = h[7:0];
    wait_rise(); measure(h, len, errs);
    wait_rise(); measure(h, len, errs);
    check(len == exp_len(code), "R1", len, exp_len(code));
    check(errs == 0, "R5/R2", errs, 0);
  endtask

  initial begin
    int len, errs, cnt, seed;
    seed = $urandom(32'h5eed);
    rst_n = 1'b0; level = '0; src_ext = 1'b0; sync_out_dis = 1'b0;
    lamp_half = 8'd3; sync_in = 1'b0;
    repeat (3) @(negedge clk);
    check(!gate_a && !gate_b && !sync_out, "R8", {gate_a, gate_b, sync_out}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(sync_oe == 1'b1, "R4", sync_oe, 1);

    level_case(0, 3);
    level_case(1, 1);
    level_case(20, 5);
    level_case(126, 0);
    for (int i = 0; i < 6; i++) level_case($urandom_range(1, 125), $urandom_range(1, 7));

    // R7: mid-period change waits for next period
    level_case(20, 2);
    wait_rise();
    level = 7'd70;
    measure(2, len, errs);
    check(len == exp_len(20), "R7", len, exp_len(20));
    wait_rise(); measure(2, len, errs);
    check(len == exp_len(70), "R7", len, exp_len(70));

    // R1: full code keeps envelope high
    level = 7'd127; lamp_half = 8'd3;
    repeat (1100) @(negedge clk);
    cnt = 0;
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      if (sync_out && (gate_a ^ gate_b)) cnt++;
    end
    check(cnt == 600, "R1", cnt, 600);

    // R4: sync output disabled, gates still run
    sync_out_dis = 1'b1;
    @(negedge clk);
    cnt = 0;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (!sync_out && !sync_oe && (gate_a ^ gate_b)) cnt++;
    end
    check(cnt == 50, "R4", cnt, 50);

    // Receiver mode
    sync_out_dis = 1'b0; src_ext = 1'b1; sync_in = 1'b0;
    @(negedge clk);
    check(!sync_oe && !sync_out, "R4", {sync_oe, sync_out}, 0);
    repeat (10) @(negedge clk);
    cnt = 0;
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      if (i == 200) level = 7'd127;
      if (i == 400) level = 7'd3;
      if (gate_a || gate_b) cnt++;
    end
    check(cnt == 0, "R6", cnt, 0);

    // R3: three-cycle latency from sync_in
    lamp_half = 8'd3;
    sync_in = 1'b1;
    @(negedge clk); @(negedge clk);
    check(!gate_a && !gate_b, "R3", gate_a | gate_b, 0);
    @(negedge clk);
    check(gate_a == 1'b1, "R3", gate_a, 1);
    errs = 0;
    for (int k = 0; k < 100; k++) begin
      if (gate_a != exp_a(k, 3) || gate_b != !exp_a(k, 3)) errs++;
      @(negedge clk);
    end
    check(errs == 0, "R5", errs, 0);
    sync_in = 1'b0;
    @(negedge clk); @(negedge clk);
    check(gate_a || gate_b, "R3", gate_a | gate_b, 1);
    @(negedge clk);
    check(!gate_a && !gate_b, "R2", gate_a | gate_b, 0);

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule